// File: doc/BRIEF.md
# UART Transmit Buffer with Status Flags

This block sits between a CPU register bus and a serial transmitter. Software writes characters through a pair of data registers. The high register carries the ninth data bit and the low register carries data bits 7:0. Each character waits in a one-deep holding buffer until the transmit shift register is free, and is then handed over as one 9-bit frame. Two status flags report progress: transmit-buffer-empty (TDRE) and transmission-complete (TC). Each flag has its own interrupt mask, and the block drives a single interrupt request.

The same two data addresses return receive data when they are read. A receiver outside this block delivers frames into a receive buffer. Reading the high register returns the received ninth bit alongside the ninth bit that software last wrote for transmission.

Software never clears a flag by writing it. A flag clears through the normal service sequence: software reads the status register while the flag is set, then writes a character to the low data register. Baud timing and bit shifting are done outside the block. The shifter takes a one-cycle load strobe and returns a one-cycle done pulse when the character has left.

Top module: `uart_txbuf`

## Requirements
- R1: After reset the control register (address 0: TE bit 0, TIE bit 1, TCIE bit 2) reads 0, the status register (address 1: TDRE bit 7, TC bit 6) reads 0, and irq is low.
- R2: A control write that changes TE from 0 to 1 sets both TDRE and TC, so that status reads 0xC0.
- R3: A status read taken while TDRE is 1, followed by a write to the low data register (address 3), clears TDRE. If TC was 1 at that read, the same write clears TC.
- R4: A write to the low data register that has no qualifying status read before it leaves TDRE and TC unchanged and starts no transfer.
- R5: When TE is 1, TDRE is 0 and the shifter is idle, sh_load pulses for one cycle in the cycle after that condition, and TDRE sets again in the same cycle. sh_data carries the ninth bit in bit 8 and the data byte in bits 7:0.
- R6: The ninth bit sent with a character is bit 6 of the high data register (address 2) as it stood when the low register was written. Later writes to the high register do not alter a character that is already queued.
- R7: On sh_done, TC sets if no character is waiting (TDRE is 1). If a character is waiting, TC stays 0 and the waiting character is loaded next.
- R8: irq is high exactly when (TIE and TDRE) or (TCIE and TC).
- R9: An rx_valid pulse captures rx_frame. A read of the high data register then returns the received ninth bit in bit 7, the transmit ninth bit in bit 6 and zero in bits 5:0. A read of the low data register returns received bits 7:0.
- R10: While TE is 0, a queued character is never loaded into the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data high, 3 data low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (arms flag clearing) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| rx_valid | input | 1 | Receiver delivers a frame |
| rx_frame | input | DATA_W+1 | Received frame, ninth bit in the top position |
| sh_load | output | 1 | One-cycle load strobe to the shift register |
| sh_data | output | DATA_W+1 | Frame handed to the shift register |
| sh_done | input | 1 | Shift register finished its character |
| irq | output | 1 | Interrupt request |

## Verification
Properties are checked on every clock, each one local to the logic it concerns. They cover: a TE rising edge sets both flags; a qualified low write clears TDRE unless a load refills it at once; an unqualified low write cannot clear TDRE; TDRE only rises through TE or a load; two loads never follow each other back to back; TC sets on a done pulse that arrives with an empty buffer; the received frame is captured; irq agrees with the masks. Other behaviour is only visible across a sequence, so the bench scenarios must show it. That covers the ninth bit being frozen at commit, a second character overlapping a busy shifter, TC staying low while a character waits, a pending character that is held while TE is 0, and the exact contents of every frame that reaches the shifter.

// File: rtl/uart_txbuf_pkg.sv
package uart_txbuf_pkg;

   // Register select; the address of the low data register matters because
   // a write to it is the commit point of the flag-clearing sequence.
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DHI  = 2'd2,
      SEL_DLO  = 2'd3
   } txb_sel_e;

   localparam int CTL_TE   = 0;
   localparam int CTL_TIE  = 1;
   localparam int CTL_TCIE = 2;

   typedef struct packed {
      logic tcie;
      logic tie;
      logic te;
   } txb_ctrl_t;

endpackage

// File: rtl/txbuf_regs.sv
module txbuf_regs
   import uart_txbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit HAS_NINTH = 1'b1,
   localparam int FRAME_W  = DATA_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               rx_valid,
   input  logic [FRAME_W-1:0] rx_frame,
   input  logic               tdre,
   input  logic               tc,
   output txb_ctrl_t          ctrl,
   output logic               te_rise,
   output logic               wr_lo,
   output logic               rd_stat,
   output logic [FRAME_W-1:0] txbuf
);

   localparam int HI_RX_BIT = DATA_W - 1;
   localparam int HI_TX_BIT = DATA_W - 2;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("txbuf_regs: DATA_W must be at least 8");
      end
   endgenerate

   txb_sel_e            sel;
   logic                wr_ctrl;
   logic                wr_hi;
   txb_ctrl_t           ctrl_q;
   logic                t8;
   logic                r8;
   logic [FRAME_W-1:0]  rxbuf_q;
   logic [FRAME_W-1:0]  txbuf_q;

   assign sel     = txb_sel_e'(bus_addr);
   assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
   assign wr_hi   = bus_wr && (sel == SEL_DHI);
   assign wr_lo   = bus_wr && (sel == SEL_DLO);
   assign rd_stat = bus_rd && (sel == SEL_STAT);
   assign te_rise = wr_ctrl && bus_wdata[CTL_TE] && !ctrl_q.te;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.te   <= bus_wdata[CTL_TE];
         ctrl_q.tie  <= bus_wdata[CTL_TIE];
         ctrl_q.tcie <= bus_wdata[CTL_TCIE];
      end
   end

   // Ninth-bit staging exists only in the 9-bit variant.
   generate
      if (HAS_NINTH) begin : g_ninth
         logic t8_q;
         always_ff @(posedge clk) begin
            if (wr_hi) begin
               t8_q <= bus_wdata[HI_TX_BIT];
            end
         end
         assign t8 = t8_q;
         assign r8 = rxbuf_q[DATA_W];
      end else begin : g_eight
         assign t8 = 1'b0;
         assign r8 = 1'b0;
      end
   endgenerate

   // Data buffers carry no reset: their contents are undefined until written.
   always_ff @(posedge clk) begin
      if (rx_valid) begin
         rxbuf_q <= rx_frame;
      end
      if (wr_lo) begin
         txbuf_q <= {t8, bus_wdata};
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata[CTL_TE]   = ctrl_q.te;
            bus_rdata[CTL_TIE]  = ctrl_q.tie;
            bus_rdata[CTL_TCIE] = ctrl_q.tcie;
         end
         SEL_STAT: begin
            bus_rdata[HI_RX_BIT] = tdre;
            bus_rdata[HI_TX_BIT] = tc;
         end
         SEL_DHI: begin
            bus_rdata[HI_RX_BIT] = r8;
            bus_rdata[HI_TX_BIT] = t8;
         end
         SEL_DLO: begin
            bus_rdata = rxbuf_q[DATA_W-1:0];
         end
         default: bus_rdata = '0;
      endcase
   end

   assign ctrl  = ctrl_q;
   assign txbuf = txbuf_q;

   // R9
   rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (rxbuf_q[DATA_W-1:0] == $past(rx_frame[DATA_W-1:0])));

   // R2
   te_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      te_rise |=> ctrl_q.te);

endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags #(
   parameter int DATA_W   = 8,
   localparam int FRAME_W = DATA_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               te,
   input  logic               te_rise,
   input  logic               rd_stat,
   input  logic               wr_lo,
   input  logic [FRAME_W-1:0] txbuf,
   input  logic               sh_done,
   output logic               tdre,
   output logic               tc,
   output logic               sh_load,
   output logic [FRAME_W-1:0] sh_data
);

   logic               tdre_q;
   logic               tc_q;
   logic               arm_tdre_q;
   logic               arm_tc_q;
   logic               busy_q;
   logic               load_q;
   logic [FRAME_W-1:0] data_q;
   logic               clr_tdre;
   logic               clr_tc;
   logic               launch;

   assign clr_tdre = wr_lo && arm_tdre_q;
   assign clr_tc   = wr_lo && arm_tc_q;
   assign launch   = te && !tdre_q && !busy_q;

   // Arming: a status read remembers which flags it saw set; the next
   // low-data write consumes the arming whether or not it clears anything.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_tdre_q <= 1'b0;
         arm_tc_q   <= 1'b0;
      end else if (wr_lo) begin
         arm_tdre_q <= 1'b0;
         arm_tc_q   <= 1'b0;
      end else if (rd_stat) begin
         arm_tdre_q <= arm_tdre_q | tdre_q;
         arm_tc_q   <= arm_tc_q | tc_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tdre_q <= 1'b0;
      end else if (te_rise || launch) begin
         tdre_q <= 1'b1;
      end else if (clr_tdre) begin
         tdre_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q <= 1'b0;
      end else if (te_rise) begin
         tc_q <= 1'b1;
      end else if (clr_tc) begin
         tc_q <= 1'b0;
      end else if (sh_done && tdre_q && !clr_tdre) begin
         tc_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         load_q <= 1'b0;
      end else begin
         load_q <= launch;
         if (launch) begin
            busy_q <= 1'b1;
         end else if (sh_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (launch) begin
         data_q <= txbuf;
      end
   end

   assign tdre    = tdre_q;
   assign tc      = tc_q;
   assign sh_load = load_q;
   assign sh_data = data_q;

   // R2
   te_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      te_rise |=> (tdre_q && tc_q));

   // R3
   clear_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && arm_tdre_q) |=> (!tdre_q || load_q));

   // R4
   no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !arm_tdre_q && tdre_q) |=> tdre_q);

   // R5
   refill_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tdre_q) && !$past(te_rise)) |-> load_q);

   // R5
   single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |=> !load_q);

   // R7
   tc_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && tdre_q && !wr_lo && !te_rise) |=> tc_q);

   // R10
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !te |=> !load_q);

endmodule

// File: rtl/txbuf_irq.sv
module txbuf_irq (
   input  logic tdre,
   input  logic tc,
   input  logic tie,
   input  logic tcie,
   output logic irq
);

   logic req_empty;
   logic req_done;

   assign req_empty = tie && tdre;
   assign req_done  = tcie && tc;
   assign irq       = req_empty || req_done;

endmodule

// File: rtl/uart_txbuf.sv
module uart_txbuf
   import uart_txbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit HAS_NINTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W:0]   rx_frame,
   output logic              sh_load,
   output logic [DATA_W:0]   sh_data,
   input  logic              sh_done,
   output logic              irq
);

   txb_ctrl_t         ctrl;
   logic              te_rise;
   logic              wr_lo;
   logic              rd_stat;
   logic [DATA_W:0]   txbuf;
   logic              tdre;
   logic              tc;

   txbuf_regs #(
      .DATA_W    (DATA_W),
      .HAS_NINTH (HAS_NINTH)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_frame  (rx_frame),
      .tdre      (tdre),
      .tc        (tc),
      .ctrl      (ctrl),
      .te_rise   (te_rise),
      .wr_lo     (wr_lo),
      .rd_stat   (rd_stat),
      .txbuf     (txbuf)
   );

   txbuf_flags #(
      .DATA_W (DATA_W)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .te      (ctrl.te),
      .te_rise (te_rise),
      .rd_stat (rd_stat),
      .wr_lo   (wr_lo),
      .txbuf   (txbuf),
      .sh_done (sh_done),
      .tdre    (tdre),
      .tc      (tc),
      .sh_load (sh_load),
      .sh_data (sh_data)
   );

   txbuf_irq u_irq (
      .tdre (tdre),
      .tc   (tc),
      .tie  (ctrl.tie),
      .tcie (ctrl.tcie),
      .irq  (irq)
   );

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.tie && !ctrl.tcie) |-> !irq);

   // R8
   irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.tie && tdre) |-> irq);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq && !sh_load));

endmodule

// File: tb/uart_txbuf_tb.sv
module uart_txbuf_tb;

   localparam int SH = 20;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DHI  = 2'd2;
   localparam logic [1:0] A_DLO  = 2'd3;
   localparam logic [8:0] CHARS [4] = '{9'h1A5, 9'h03C, 9'h100, 9'h0FF};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_valid = 1'b0;
   logic [8:0] rx_frame = '0;
   logic       sh_load;
   logic [8:0] sh_data;
   logic       sh_done;
   logic       irq;

   int nchk = 0;
   int nerr = 0;
   int nload;
   int ndone;
   int cnt;
   logic [8:0] frames [16];
   logic [7:0] rv;

   always #4 clk = ~clk;

   uart_txbuf u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_frame  (rx_frame),
      .sh_load   (sh_load),
      .sh_data   (sh_data),
      .sh_done   (sh_done),
      .irq       (irq)
   );

   // Stand-in shifter: records each loaded frame, reports done SH cycles later.
   always @(posedge clk) begin
      if (!rst_n) begin
         nload   <= 0;
         ndone   <= 0;
         cnt     <= 0;
         sh_done <= 1'b0;
      end else begin
         sh_done <= 1'b0;
         if (sh_load) begin
            frames[nload % 16] <= sh_data;
            nload <= nload + 1;
            cnt   <= SH;
         end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
               sh_done <= 1'b1;
               ndone   <= ndone + 1;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_loads(input int n);
      for (int k = 0; k < 200 && nload < n; k++) @(negedge clk);
   endtask

   task automatic wait_dones(input int n);
      for (int k = 0; k < 200 && ndone < n; k++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, rv); chk("R1 ctrl", {1'b0, rv}, 9'h000);
      rd(A_STAT, rv); chk("R1 status", {1'b0, rv}, 9'h000);
      chk("R1 irq", {8'h0, irq}, 9'h000);

      // R2 enable transmitter
      wr(A_CTRL, 8'h01);
      rd(A_STAT, rv); chk("R2 flags on TE rise", {1'b0, rv}, 9'h0C0);

      // Vector table: each character through the full service sequence (R3, R5, R6)
      for (int i = 0; i < 4; i++) begin
         rd(A_STAT, rv);
         chk("R3 TDRE before write", {8'h0, rv[7]}, 9'h001);
         wr(A_DHI, {1'b0, CHARS[i][8], 6'b0});
         wr(A_DLO, CHARS[i][7:0]);
         wait_loads(i + 1);
         chk("R5 frame to shifter", frames[i], CHARS[i]);
         wait_dones(i + 1);
      end

      // R9 receive path
      @(negedge clk); rx_valid = 1'b1; rx_frame = 9'h15A;
      @(negedge clk); rx_valid = 1'b0;
      rd(A_DHI, rv); chk("R9 high read", {1'b0, rv}, 9'h080);
      rd(A_DLO, rv); chk("R9 low read", {1'b0, rv}, 9'h05A);

      // R4 low write with no status read before it
      wr(A_DLO, 8'h77);
      repeat (10) @(negedge clk);
      chk("R4 no load", nload[8:0], 9'd4);
      rd(A_STAT, rv); chk("R4 flags kept", {1'b0, rv}, 9'h0C0);

      // R6/R7 second character while shifter busy
      rd(A_STAT, rv);
      wr(A_DHI, 8'h40);
      wr(A_DLO, 8'h11);
      rd(A_STAT, rv); chk("R3 TC cleared, TDRE refilled", {1'b0, rv}, 9'h080);
      wr(A_DHI, 8'h00);
      wr(A_DLO, 8'h22);
      wr(A_DHI, 8'h40);
      rd(A_STAT, rv); chk("R3 both flags clear while queued", {1'b0, rv}, 9'h000);
      wait_loads(6);
      chk("R6 first frame", frames[4], 9'h111);
      chk("R6 queued ninth bit frozen", frames[5], 9'h022);
      rd(A_STAT, rv); chk("R7 no TC while char waited", {1'b0, rv}, 9'h080);
      wait_dones(6);
      rd(A_STAT, rv); chk("R7 TC after last char", {1'b0, rv}, 9'h0C0);

      // R8 interrupt masks
      wr(A_CTRL, 8'h03); chk("R8 TIE irq", {8'h0, irq}, 9'h001);
      wr(A_CTRL, 8'h01); chk("R8 masked irq", {8'h0, irq}, 9'h000);
      wr(A_CTRL, 8'h05); chk("R8 TCIE irq", {8'h0, irq}, 9'h001);
      rd(A_STAT, rv);
      wr(A_DLO, 8'h33);
      chk("R5 no load in write cycle", {8'h0, sh_load}, 9'h000);
      chk("R8 irq drops with TC", {8'h0, irq}, 9'h000);
      @(negedge clk);
      chk("R5 load one cycle later", {8'h0, sh_load}, 9'h001);
      chk("R5 load data", sh_data, 9'h133);
      wait_dones(7);
      chk("R8 irq on TC", {8'h0, irq}, 9'h001);

      // R10 transmitter disabled holds the character
      wr(A_CTRL, 8'h00);
      rd(A_STAT, rv);
      wr(A_DLO, 8'h44);
      repeat (10) @(negedge clk);
      chk("R10 no load while off", nload[8:0], 9'd7);
      rd(A_STAT, rv); chk("R10 flags cleared while off", {1'b0, rv}, 9'h000);
      wr(A_CTRL, 8'h01);
      rd(A_STAT, rv); chk("R2 flags on second TE rise", {1'b0, rv}, 9'h0C0);
      repeat (5) @(negedge clk);
      chk("R10 nothing sent after re-enable", nload[8:0], 9'd7);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule